// File: doc/BRIEF.md
# Synthesizer Serial Register Link

This block moves 32-bit configuration words from a host into an external frequency-synthesizer device. The link is a one-way serial shift path made of a clock, a data line and a separate latch strobe. The block can also fetch one 32-bit status word from the device over a data-return line. The host supplies a 3-bit register index, a 32-bit value, a read/write selector and a start pulse. It gets back a busy flag, a one-cycle completion pulse and the last status word read.

A write works as follows. A quiet interval comes first. The block then shifts out a frame whose low three bits carry the register index, most significant bit first. After the frame it pulses the latch strobe so that the device commits the word. A readback first sends a fixed request frame that addresses status register 6. It then raises the latch strobe and keeps it high for the whole return phase. During that phase the block clocks a further 32 bits, driving zeros out and collecting the returning bits. Before the block hands the collected word to the host, it moves the word two places toward the MSB.

The serial clock half-period, the quiet interval and the strobe width are parameters counted in system-clock cycles. With the defaults and a 50 MHz system clock, the quiet interval and the strobe each last 1 µs.

Top module: `synth_reg_link`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, sclk_o, mosi_o and le_o are 0 and rdata_o is 0.
- R2: A write sends 32 bits MSB first. Frame bits [31:3] are value_i[31:3] and frame bits [2:0] are reg_idx_i.
- R3: sclk_o is low when no bit is being sent. Each bit keeps sclk_o low for HALF_CYC cycles and then high for HALF_CYC cycles. mosi_o changes only when sclk_o falls and is stable while sclk_o is high, so the device samples on the rising edge.
- R4: busy_o goes high in the cycle after a start is accepted. Before the first bit there are GAP_CYC cycles with sclk_o and le_o low, during which mosi_o already shows frame bit 31.
- R5: After the last bit of a write frame, le_o is high for STROBE_CYC cycles with sclk_o and mosi_o low. It then returns low.
- R6: A readback (read_i=1) sends the frame 0x00000006, whatever reg_idx_i and value_i hold.
- R7: After the readback request frame, le_o goes high and stays high for STROBE_CYC cycles plus 32 further clock periods, during which mosi_o is 0. le_o falls only after the last of those periods.
- R8: miso_i is sampled at each rising sclk_o of the return phase, first bit into bit 31. rdata_o becomes the captured word shifted left by 2 (bits [1:0] are 0) in the cycle done_o is high, and otherwise holds.
- R9: A start request while busy_o is high is ignored, and the transaction in progress runs unchanged.
- R10: done_o is high for exactly one cycle at the end of each transaction, and busy_o is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transaction (accepted only while idle) |
| read_i | input | 1 | 1 = readback of status register, 0 = register write |
| reg_idx_i | input | 3 | Register index placed in frame bits [2:0] |
| value_i | input | 32 | Write value, bits [31:3] used |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Last readback word, aligned left by 2 |
| sclk_o | output | 1 | Serial clock to device, idles low |
| mosi_o | output | 1 | Serial data to device |
| le_o | output | 1 | Latch strobe to device |
| miso_i | input | 1 | Serial data returned by device |

## Verification
Writes use three different values. One is an irregular value whose index overwrites set low bits. One has only its low three bits set, with index 0, which checks that value bits [2:0] are dropped. One has all bits set, with index 7, which shows the field boundary. Two readbacks carry non-zero index and value on the inputs, and their return patterns differ. One is an irregular pattern and the other is all ones. Together they show the fixed request frame, the bit order of the return phase and the two-place alignment. A second start pulse raised in the middle of a write must leave the waveform and the strobe count exactly as a lone write would have them.

// File: rtl/synth_link_pkg.sv
package synth_link_pkg;

   typedef enum logic [2:0] {
      LK_IDLE   = 3'd0,
      LK_GAP    = 3'd1,
      LK_SEND   = 3'd2,
      LK_STROBE = 3'd3,
      LK_RECV   = 3'd4
   } link_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sl_timer.sv
module sl_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;

   assign hit_o = (cnt_q == limit_i) && !clr_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i || hit_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_val_i,
   input  logic              shift_i,
   input  logic              cap_i,
   input  logic              miso_i,
   output logic              msb_o,
   output logic [WORD_W-1:0] cap_o
);
   logic [WORD_W-1:0] out_q;
   logic [WORD_W-1:0] in_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (load_i) begin
         out_q <= load_val_i;
      end else if (shift_i) begin
         out_q <= {out_q[WORD_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q <= '0;
      end else if (cap_i) begin
         in_q <= {in_q[WORD_W-2:0], miso_i};
      end
   end

   assign msb_o = out_q[WORD_W-1];
   assign cap_o = in_q;

   p_load_shift_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && shift_i));
endmodule

// File: rtl/synth_reg_link.sv
module synth_reg_link
   import synth_link_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 3,
   parameter int STATUS_IDX = 6,
   parameter int RB_ALIGN   = 2,
   parameter int HALF_CYC   = 2,
   parameter int GAP_CYC    = 50,
   parameter int STROBE_CYC = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              read_i,
   input  logic [IDX_W-1:0]  reg_idx_i,
   input  logic [DATA_W-1:0] value_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              le_o,
   input  logic              miso_i
);
   localparam int unsigned LIM_MAX = max3(HALF_CYC, GAP_CYC, STROBE_CYC);
   localparam int          CNT_W   = $clog2(LIM_MAX + 1);
   localparam int          BIT_W   = $clog2(DATA_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   if (HALF_CYC < 1)   $error("HALF_CYC must be at least 1");
   if (GAP_CYC < 1)    $error("GAP_CYC must be at least 1");
   if (STROBE_CYC < 1) $error("STROBE_CYC must be at least 1");
   if (IDX_W >= DATA_W) $error("IDX_W must be smaller than DATA_W");
   if (STATUS_IDX >= (1 << IDX_W)) $error("STATUS_IDX does not fit the index field");
   if (RB_ALIGN >= DATA_W) $error("RB_ALIGN must be smaller than DATA_W");

   link_state_e      state_q;
   logic             rd_q;
   logic             phase_hi_q;
   logic [BIT_W-1:0] bit_q;
   logic [DATA_W-1:0] rdata_q;
   logic             done_q;

   logic             tmr_clr;
   logic [CNT_W-1:0] tmr_lim;
   logic             tmr_hit;
   logic             accept;
   logic [DATA_W-1:0] frame;
   logic             sh_shift;
   logic             sh_cap;
   logic             sh_msb;
   logic [DATA_W-1:0] sh_cap_word;
   logic [DATA_W-1:0] rb_word;

   // ---------------- frame assembly ----------------
   assign accept = (state_q == LK_IDLE) && start_i;
   assign frame  = read_i ? DATA_W'(STATUS_IDX)
                          : {value_i[DATA_W-1:IDX_W], reg_idx_i};

   // ---------------- readback alignment ----------------
   if (RB_ALIGN == 0) begin : g_rb_plain
      assign rb_word = sh_cap_word;
   end else begin : g_rb_shift
      assign rb_word = {sh_cap_word[DATA_W-1-RB_ALIGN:0], {RB_ALIGN{1'b0}}};
   end

   // ---------------- interval timer ----------------
   always_comb begin
      tmr_clr = 1'b0;
      tmr_lim = '0;
      unique case (state_q)
         LK_GAP:           tmr_lim = CNT_W'(GAP_CYC - 1);
         LK_SEND, LK_RECV: tmr_lim = CNT_W'(HALF_CYC - 1);
         LK_STROBE:        tmr_lim = CNT_W'(STROBE_CYC - 1);
         default:          tmr_clr = 1'b1;
      endcase
   end

   sl_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tmr_clr),
      .limit_i (tmr_lim),
      .hit_o   (tmr_hit)
   );

   // ---------------- shift datapath ----------------
   assign sh_shift = (state_q == LK_SEND) && tmr_hit && phase_hi_q && (bit_q != LAST_BIT);
   assign sh_cap   = (state_q == LK_RECV) && tmr_hit && !phase_hi_q;

   sl_shifter #(.WORD_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (frame),
      .shift_i    (sh_shift),
      .cap_i      (sh_cap),
      .miso_i     (miso_i),
      .msb_o      (sh_msb),
      .cap_o      (sh_cap_word)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= LK_IDLE;
         rd_q       <= 1'b0;
         phase_hi_q <= 1'b0;
         bit_q      <= '0;
         rdata_q    <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            LK_IDLE: begin
               if (start_i) begin
                  state_q <= LK_GAP;
                  rd_q    <= read_i;
               end
            end
            LK_GAP: begin
               if (tmr_hit) begin
                  state_q    <= LK_SEND;
                  phase_hi_q <= 1'b0;
                  bit_q      <= '0;
               end
            end
            LK_SEND, LK_RECV: begin
               if (tmr_hit) begin
                  if (!phase_hi_q) begin
                     phase_hi_q <= 1'b1;
                  end else begin
                     phase_hi_q <= 1'b0;
                     if (bit_q == LAST_BIT) begin
                        bit_q <= '0;
                        if (state_q == LK_SEND) begin
                           state_q <= LK_STROBE;
                        end else begin
                           state_q <= LK_IDLE;
                           done_q  <= 1'b1;
                           rdata_q <= rb_word;
                        end
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end
            end
            LK_STROBE: begin
               if (tmr_hit) begin
                  if (rd_q) begin
                     state_q    <= LK_RECV;
                     phase_hi_q <= 1'b0;
                     bit_q      <= '0;
                  end else begin
                     state_q <= LK_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= LK_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign busy_o  = (state_q != LK_IDLE);
   assign done_o  = done_q;
   assign rdata_o = rdata_q;
   assign sclk_o  = ((state_q == LK_SEND) || (state_q == LK_RECV)) && phase_hi_q;
   assign le_o    = (state_q == LK_STROBE) || (state_q == LK_RECV);
   assign mosi_o  = ((state_q == LK_GAP) || (state_q == LK_SEND)) && sh_msb;

   // ---------------- assertions ----------------
   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sclk_o);
   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
   p_strobe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (le_o && !rd_q) |-> (!sclk_o && !mosi_o));
   p_recv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LK_RECV) |-> (!mosi_o && le_o));
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(rd_q));
   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rdata_o));
   p_rdata_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[1:0] == 2'b00);
endmodule

// File: tb/sim_synth_reg_link.sv
module sim_synth_reg_link;
   localparam int HALF   = 2;
   localparam int GAP    = 50;
   localparam int STROBE = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        read_i = 1'b0;
   logic [2:0]  reg_idx_i = '0;
   logic [31:0] value_i = '0;
   logic        busy_o, done_o, sclk_o, mosi_o, le_o;
   logic [31:0] rdata_o;
   logic        miso_i = 1'b0;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   synth_reg_link #(.HALF_CYC(HALF), .GAP_CYC(GAP), .STROBE_CYC(STROBE)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .read_i(read_i),
      .reg_idx_i(reg_idx_i), .value_i(value_i), .busy_o(busy_o), .done_o(done_o),
      .rdata_o(rdata_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .le_o(le_o), .miso_i(miso_i)
   );

   // expected entry: {busy, sclk, mosi, le, done}
   logic [4:0]  exp_q[$];
   logic        cur_rd = 1'b0;
   logic [31:0] slave_word = '0;
   logic [31:0] exp_rdata = '0;
   int          le_cycles = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_expect(input logic rd, input logic [31:0] fr);
      for (int i = 0; i < GAP; i++) exp_q.push_back({1'b1, 1'b0, fr[31], 1'b0, 1'b0});
      for (int b = 31; b >= 0; b--) begin
         for (int i = 0; i < HALF; i++) exp_q.push_back({1'b1, 1'b0, fr[b], 1'b0, 1'b0});
         for (int i = 0; i < HALF; i++) exp_q.push_back({1'b1, 1'b1, fr[b], 1'b0, 1'b0});
      end
      for (int i = 0; i < STROBE; i++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
      if (rd) begin
         for (int b = 0; b < 32; b++) begin
            for (int i = 0; i < HALF; i++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
            for (int i = 0; i < HALF; i++) exp_q.push_back({1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
         end
      end
      exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
   endtask

   // cycle-by-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [4:0] e;
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 5'b0;
         check("R4 busy", {31'b0, busy_o}, {31'b0, e[4]});
         check("R3 sclk", {31'b0, sclk_o}, {31'b0, e[3]});
         check(e[1] ? "R7 mosi" : (cur_rd ? "R6 mosi" : "R2 mosi"),
               {31'b0, mosi_o}, {31'b0, e[2]});
         check(cur_rd ? "R7 le" : "R5 le", {31'b0, le_o}, {31'b0, e[1]});
         check("R10 done", {31'b0, done_o}, {31'b0, e[0]});
         if (e[0] && cur_rd) check("R8 rdata", rdata_o, exp_rdata);
         if (le_o) le_cycles++;
      end
   end

   // device model: return word MSB first, next bit after each falling sclk
   logic prev_le = 1'b0, prev_sclk = 1'b0;
   int   rbit = 0;
   always @(negedge clk) begin
      if (le_o && !prev_le) begin
         rbit   = 0;
         miso_i <= slave_word[31];
      end else if (le_o && prev_sclk && !sclk_o) begin
         rbit++;
         if (rbit < 32) miso_i <= slave_word[31 - rbit];
      end
      prev_le   = le_o;
      prev_sclk = sclk_o;
   end

   task automatic run(input logic rd, input logic [2:0] idx, input logic [31:0] val,
                      input bit poke_busy);
      logic [31:0] fr;
      fr = rd ? 32'h0000_0006 : {val[31:3], idx};
      @(negedge clk); #2;
      cur_rd = rd;
      exp_rdata = slave_word << 2;
      le_cycles = 0;
      start_i = 1'b1; read_i = rd; reg_idx_i = idx; value_i = val;
      push_expect(rd, fr);
      @(negedge clk); #2;
      start_i = 1'b0;
      if (poke_busy) begin
         repeat (5) @(negedge clk);
         #2 start_i = 1'b1; read_i = 1'b1; reg_idx_i = 3'd2; value_i = 32'h1234_5678;
         @(negedge clk); #2 start_i = 1'b0;
      end
      while (exp_q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 busy", {31'b0, busy_o}, 32'd0);
      check("R1 sclk", {31'b0, sclk_o}, 32'd0);
      check("R1 le",   {31'b0, le_o},   32'd0);
      check("R1 mosi", {31'b0, mosi_o}, 32'd0);
      check("R1 done", {31'b0, done_o}, 32'd0);
      check("R1 rdata", rdata_o, 32'd0);
      @(negedge clk); #2 rst_n = 1'b1;

      run(1'b0, 3'd5, 32'hDEAD_BEEF, 1'b0);       // R2 irregular value
      run(1'b0, 3'd0, 32'h0000_0007, 1'b0);       // R2 low value bits dropped
      run(1'b0, 3'd7, 32'hFFFF_FFFF, 1'b0);       // R2 field boundary
      slave_word = 32'hA5C3_1E7F;
      run(1'b1, 3'd3, 32'hCAFE_F00D, 1'b0);       // R6 R7 R8
      check("R8 rdata hold", rdata_o, 32'hA5C3_1E7F << 2);
      slave_word = 32'hFFFF_FFFF;
      run(1'b1, 3'd1, 32'h0F0F_0F0F, 1'b0);       // R8 low bits zero
      check("R8 rdata ones", rdata_o, 32'hFFFF_FFFC);
      run(1'b0, 3'd4, 32'h8000_0001, 1'b1);       // R9 start while busy
      check("R9 strobe count", le_cycles, STROBE);
      check("R9 rdata kept", rdata_o, 32'hFFFF_FFFC);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule